// File: doc/BRIEF.md
# Screen-shadowing DRAM controller

This block connects a 68000-family processor whose data bus is eight bits wide to one x8 DRAM device with 16M locations. It runs from a timing clock at twice the processor clock and in lockstep with it. Every access opens a row, strobes a column and then precharges, with no page mode. The whole sequence fits inside the four-clock processor bus cycle, so the acknowledge arrives with no wait states.

A configurable window of addresses holds the screen memory. A write into this window updates the DRAM and is also copied to a slow legacy display bus, which uses a four-phase request/acknowledge handshake. The copy goes out through a one-entry write buffer, so the processor does not wait for the display bus. A read from the window is served from the DRAM alone. A refresh timer inserts CAS-before-RAS refresh cycles between processor accesses.

Top module: `shadow_dram_ctrl`

## Requirements
- R1: While reset is held and right after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, and `cpu_ack` and `dsp_req` are low.
- R2: When no refresh is pending and the write buffer is not needed, `cpu_ack` rises on the fifth rising clock edge counted from the edge that samples `cpu_req` (edge k samples the request, `cpu_ack` rises at edge k+4). It stays high for exactly one clock.
- R3: The row address is `cpu_addr[23:12]`. It is driven one clock before RAS falls and is held while RAS falls. The column address is `cpu_addr[11:0]`, driven as CAS falls. RAS and CAS return high after every access (no page mode).
- R4: CAS falls exactly one clock after RAS falls. CAS stays low for two clocks. RAS is high for at least two clocks before it falls again.
- R5: For a read, `cpu_rdata` is valid while `cpu_ack` is high and holds the byte stored at that address.
- R6: The shadow window starts at `SCR_BASE`. It spans 64 KB when `cfg_wide`=0 and 96 KB when `cfg_wide`=1. Each write inside the window raises exactly one display request carrying the same address and data. A write outside the window raises none.
- R7: A read, inside the window or outside it, produces no display bus request.
- R8: A shadowed write that finds the buffer empty completes with the same zero-wait timing as R2. A shadowed write that finds the buffer full is not acknowledged until the buffer has drained.
- R9: `dsp_req` stays high until `dsp_ack` is seen. A new request starts only after `dsp_ack` has gone low again.
- R10: One CAS-before-RAS refresh (CAS falls while RAS is high) is issued every `REF_PERIOD` clocks. It starts only when no access is in progress. A processor request that arrives while the refresh is running waits for the refresh to finish.
- R11: `dram_we_n` is low while CAS is low on a write access and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Timing clock, twice the processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects the 96 KB shadow window |
| cpu_req | input | 1 | Processor access request, held until acknowledge |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 24 | Processor byte address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with acknowledge |
| cpu_ack | output | 1 | One-clock transfer acknowledge |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_wdata | output | 8 | Data driven to the DRAM |
| dram_rdata | input | 8 | Data returned by the DRAM |
| dsp_req | output | 1 | Display bus write request |
| dsp_addr | output | 24 | Display bus write address |
| dsp_wdata | output | 8 | Display bus write data |
| dsp_ack | input | 1 | Display bus acknowledge |

## Verification
The hardest case to reach from the ports is a shadowed write that finds the buffer still full. This needs a slow display bus and a second window write issued straight after the first one is acknowledged. The bench lengthens the latency of its display model for one test and issues two back-to-back window writes, so the second must stall. Refresh cycles arrive at times the bench does not schedule. The bench therefore counts the refresh strobes in its DRAM model during each access, and it allows the longer acknowledge only when a refresh has actually occurred.

// File: rtl/shadow_dram_pkg.sv
package shadow_dram_pkg;
  localparam int ADDR_W  = 24;
  localparam int DRAM_AW = 12;
  localparam int DATA_W  = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_RCD, S_CAS1, S_CAS2, S_PRE1, S_PRE2,
    S_RF1, S_RF2, S_RF3
  } seq_state_t;

  function automatic logic [DRAM_AW-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: DRAM_AW];
  endfunction

  function automatic logic [DRAM_AW-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[DRAM_AW-1:0];
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W:0]   span);
    logic [ADDR_W:0] off;
    off = {1'b0, a} - {1'b0, base};
    return (a >= base) && (off < span);
  endfunction

  function automatic logic ras_active(input seq_state_t s);
    return (s == S_RCD) || (s == S_CAS1) || (s == S_CAS2) ||
           (s == S_RF2) || (s == S_RF3);
  endfunction

  function automatic logic cas_active(input seq_state_t s);
    return (s == S_CAS1) || (s == S_CAS2) ||
           (s == S_RF1) || (s == S_RF2) || (s == S_RF3);
  endfunction
endpackage

// File: rtl/shadow_refresh_timer.sv
module shadow_refresh_timer #(
  parameter int unsigned PERIOD = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_take,
  output logic ref_pend
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= CW'(PERIOD - 1);
      ref_pend <= 1'b0;
    end else begin
      if (cnt == '0) begin
        cnt      <= CW'(PERIOD - 1);
        ref_pend <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
        if (ref_take) ref_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shadow_write_buffer.sv
module shadow_write_buffer
  import shadow_dram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              full,
  output logic              dsp_req,
  output logic [ADDR_W-1:0] dsp_addr,
  output logic [DATA_W-1:0] dsp_wdata,
  input  logic              dsp_ack
);
  logic wait_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      dsp_req   <= 1'b0;
      wait_low  <= 1'b0;
      dsp_addr  <= '0;
      dsp_wdata <= '0;
    end else begin
      if (load) begin
        full      <= 1'b1;
        dsp_addr  <= ld_addr;
        dsp_wdata <= ld_data;
      end
      if (full && !dsp_req && !wait_low) dsp_req <= 1'b1;
      if (dsp_req && dsp_ack) begin
        dsp_req  <= 1'b0;
        full     <= 1'b0;
        wait_low <= 1'b1;
      end
      if (wait_low && !dsp_ack) wait_low <= 1'b0;
    end
  end
endmodule

// File: rtl/shadow_dram_seq.sv
module shadow_dram_seq
  import shadow_dram_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_rw,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               win_hit,
  input  logic               buf_full,
  input  logic               ref_pend,
  input  logic [DATA_W-1:0]  dram_rdata,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic [DATA_W-1:0]  dram_wdata,
  output logic               cpu_ack,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               ref_take,
  output logic               acc_start,
  output logic               buf_load
);
  seq_state_t        st, nx;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              go;

  assign go       = cpu_req && !(!cpu_rw && win_hit && buf_full);
  assign buf_load = acc_start && !cpu_rw && win_hit;

  always_comb begin
    nx        = st;
    ref_take  = 1'b0;
    acc_start = 1'b0;
    case (st)
      S_IDLE: begin
        if (ref_pend) begin
          nx       = S_RF1;
          ref_take = 1'b1;
        end else if (go) begin
          nx        = S_ROW;
          acc_start = 1'b1;
        end
      end
      S_ROW:   nx = S_RCD;
      S_RCD:   nx = S_CAS1;
      S_CAS1:  nx = S_CAS2;
      S_CAS2:  nx = S_PRE1;
      S_PRE1:  nx = S_PRE2;
      S_PRE2:  nx = S_IDLE;
      S_RF1:   nx = S_RF2;
      S_RF2:   nx = S_RF3;
      S_RF3:   nx = S_PRE1;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ras_n      <= 1'b1;
      cas_n      <= 1'b1;
      we_n       <= 1'b1;
      dram_addr  <= '0;
      dram_wdata <= '0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      cpu_ack    <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      st    <= nx;
      ras_n <= !ras_active(nx);
      cas_n <= !cas_active(nx);
      we_n  <= !(wr_q && ((nx == S_CAS1) || (nx == S_CAS2)));
      if (acc_start) begin
        wr_q       <= !cpu_rw;
        addr_q     <= cpu_addr;
        dram_wdata <= cpu_wdata;
        dram_addr  <= row_of(cpu_addr);
      end else if (nx == S_CAS1) begin
        dram_addr <= col_of(addr_q);
      end
      cpu_ack <= (st == S_CAS2);
      if (st == S_CAS2 && !wr_q) cpu_rdata <= dram_rdata;
    end
  end
endmodule

// File: rtl/shadow_dram_ctrl.sv
module shadow_dram_ctrl
  import shadow_dram_pkg::*;
#(
  parameter logic [23:0] SCR_BASE     = 24'h020000,
  parameter int unsigned NARROW_BYTES = 65536,
  parameter int unsigned WIDE_BYTES   = 98304,
  parameter int unsigned REF_PERIOD   = 500
) (
  input  logic               clk2x,
  input  logic               rst_n,
  input  logic               cfg_wide,
  input  logic               cpu_req,
  input  logic               cpu_rw,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_ack,
  output logic               dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic [DATA_W-1:0]  dram_wdata,
  input  logic [DATA_W-1:0]  dram_rdata,
  output logic               dsp_req,
  output logic [ADDR_W-1:0]  dsp_addr,
  output logic [DATA_W-1:0]  dsp_wdata,
  input  logic               dsp_ack
);
  localparam logic [ADDR_W:0] NSPAN = (ADDR_W+1)'(NARROW_BYTES);
  localparam logic [ADDR_W:0] WSPAN = (ADDR_W+1)'(WIDE_BYTES);

  logic win_hit, buf_full, buf_load, ref_pend, ref_take, acc_start;

  assign win_hit = in_window(cpu_addr, SCR_BASE, cfg_wide ? WSPAN : NSPAN);

  shadow_refresh_timer #(.PERIOD(REF_PERIOD)) u_ref (
    .clk(clk2x), .rst_n(rst_n), .ref_take(ref_take), .ref_pend(ref_pend)
  );

  shadow_dram_seq u_seq (
    .clk(clk2x), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .win_hit(win_hit),
    .buf_full(buf_full), .ref_pend(ref_pend), .dram_rdata(dram_rdata),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .ref_take(ref_take), .acc_start(acc_start),
    .buf_load(buf_load)
  );

  shadow_write_buffer u_buf (
    .clk(clk2x), .rst_n(rst_n), .load(buf_load), .ld_addr(cpu_addr),
    .ld_data(cpu_wdata), .full(buf_full), .dsp_req(dsp_req),
    .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_ack(dsp_ack)
  );
endmodule

// File: rtl/shadow_dram_chk.sv
module shadow_dram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [11:0] addr,
  input logic        cpu_ack,
  input logic        acc_start,
  input logic        write_win,
  input logic        buf_full,
  input logic        dsp_req,
  input logic        dsp_ack
);
  // R2
  ack_zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> ##5 cpu_ack);

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R3
  row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |-> $stable(addr));

  // R4
  ras_to_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> $past(!ras_n));

  // R4
  cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |=> !cas_n);

  // R4
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

  // R8
  buffer_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && write_win) |-> !buf_full);

  // R9
  dsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req && !dsp_ack) |=> dsp_req);

  // R11
  we_only_with_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n);
endmodule

bind shadow_dram_ctrl shadow_dram_chk u_chk (
  .clk(clk2x), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .addr(dram_addr), .cpu_ack(cpu_ack),
  .acc_start(acc_start), .write_win(buf_load), .buf_full(buf_full),
  .dsp_req(dsp_req), .dsp_ack(dsp_ack)
);

// File: tb/shadow_dram_ctrl_tb.sv
module shadow_dram_ctrl_tb;
  localparam int P = 64;
  logic clk = 0, rst_n = 0, cfg_wide = 0;
  logic cpu_req = 0, cpu_rw = 1;
  logic [23:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata, dram_rdata = 0, dram_wdata, dsp_wdata;
  logic cpu_ack, ras_n, cas_n, we_n, dsp_req, dsp_ack = 0;
  logic [11:0] dram_addr;
  logic [23:0] dsp_addr;

  always #4 clk = ~clk;

  shadow_dram_ctrl #(.REF_PERIOD(P)) u_dut (
    .clk2x(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cpu_req(cpu_req),
    .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .dsp_req(dsp_req),
    .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_ack(dsp_ack)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  int m_ref = 0, m_wr = 0, t_err = 0, d_cnt = 0, d_err = 0, dsp_lat = 3;
  logic [7:0] mem  [int unsigned];
  logic [7:0] dmem [int unsigned];
  logic [7:0] bref [int unsigned];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // DRAM model, with timing bookkeeping for R3/R4
  logic p_ras = 1, p_cas = 1;
  int ras_age = 0, ras_hi = 10, cas_age = 0;
  logic [11:0] row = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && p_ras) begin
        if (cas_n) row = dram_addr;
        if (ras_hi < 2) t_err++;
        ras_age = 0; ras_hi = 0;
      end else if (!ras_n) ras_age++;
      else ras_hi++;
      if (!cas_n && p_cas) begin
        if (ras_n) m_ref++;
        else begin
          if (ras_age != 1) t_err++;
          if (!we_n) begin mem[{8'h0, row, dram_addr}] = dram_wdata; m_wr++; end
          else dram_rdata = mem.exists({8'h0, row, dram_addr}) ? mem[{8'h0, row, dram_addr}] : 8'h00;
        end
        cas_age = 0;
      end else if (!cas_n) cas_age++;
      if (cas_n && !p_cas && cas_age < 1) t_err++;
    end
    p_ras = ras_n; p_cas = cas_n;
  end

  // display bus model
  logic p_req = 0;
  int dwait = 0;
  always @(negedge clk) begin
    if (dsp_req && !p_req) d_cnt++;
    if (!dsp_req && p_req && !dsp_ack) d_err++;
    if (dsp_req && !p_req && dsp_ack) d_err++;
    if (dsp_req && !dsp_ack) begin
      if (dwait >= dsp_lat) begin
        dmem[{8'h0, dsp_addr}] = dsp_wdata; dsp_ack = 1; dwait = 0;
      end else dwait++;
    end else if (!dsp_req) dsp_ack = 0;
    p_req = dsp_req;
  end

  function automatic bit in_win(input logic [23:0] a, input bit wide);
    return (a >= 24'h020000) && (a < (wide ? 24'h038000 : 24'h030000));
  endfunction

  int lat, rf0, wr0, ds0;
  logic [7:0] rd;
  task automatic access(input bit wr, input logic [23:0] a, input logic [7:0] d);
    rf0 = m_ref;
    repeat (8) @(negedge clk);
    wr0 = m_wr; ds0 = d_cnt;
    cpu_req = 1; cpu_rw = !wr; cpu_addr = a; cpu_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 100);
    rd = cpu_rdata;
    cpu_req = 0;
    if (wr) bref[{8'h0, a}] = d;
  endtask

  // {write, address, data}
  localparam logic [32:0] VEC [10] = '{
    {1'b1, 24'h001234, 8'hA5}, {1'b0, 24'h001234, 8'hA5},
    {1'b1, 24'h020010, 8'h3C}, {1'b0, 24'h020010, 8'h3C},
    {1'b1, 24'hABC0FF, 8'h5A}, {1'b1, 24'h02FFFF, 8'hC3},
    {1'b0, 24'h02FFFF, 8'hC3}, {1'b1, 24'h030000, 8'h77},
    {1'b0, 24'hABC0FF, 8'h5A}, {1'b1, 24'h01FFFF, 8'h11}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && !cpu_ack && !dsp_req, "R1", {ras_n, cas_n, we_n, cpu_ack, dsp_req}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && !cpu_ack && !dsp_req, "R1", {ras_n, cas_n, cpu_ack, dsp_req}, 4'b1100);

    for (int i = 0; i < 10; i++) begin
      bit w; logic [23:0] a; logic [7:0] d;
      {w, a, d} = VEC[i];
      access(w, a, d);
      // R2 / R8 zero wait unless a refresh was seen
      chk(lat == 5 || (m_ref != rf0 && lat <= 12), "R2", lat, 5);
      chk((m_wr - wr0) == (w ? 1 : 0), "R11", m_wr - wr0, w ? 1 : 0);
      if (w) chk((d_cnt - ds0) == (in_win(a, 0) ? 1 : 0), "R6", d_cnt - ds0, in_win(a, 0) ? 1 : 0);
      else begin
        chk(rd == d, "R5", rd, d);
        chk(d_cnt == ds0, "R7", d_cnt - ds0, 0);
      end
    end
    repeat (20) @(negedge clk);
    // R6 both copies agree; R3 DRAM copy at row/column-decoded location
    chk(dmem.exists(32'h020010) && dmem[32'h020010] == 8'h3C, "R6", dmem[32'h020010], 8'h3C);
    chk(dmem.exists(32'h02FFFF) && dmem[32'h02FFFF] == 8'hC3, "R6", dmem[32'h02FFFF], 8'hC3);
    chk(!dmem.exists(32'h030000), "R6", 1, 0);
    chk(mem.exists(32'hABC0FF) && mem[32'hABC0FF] == 8'h5A, "R3", mem[32'hABC0FF], 8'h5A);

    // R6 wide window
    cfg_wide = 1;
    access(1, 24'h030000, 8'h99);
    chk(d_cnt - ds0 == 1, "R6", d_cnt - ds0, 1);
    repeat (20) @(negedge clk);
    chk(dmem[32'h030000] == 8'h99, "R6", dmem[32'h030000], 8'h99);
    cfg_wide = 0;

    // R8 buffer full stalls
    dsp_lat = 20;
    access(1, 24'h020100, 8'h01);
    chk(lat == 5 || (m_ref != rf0 && lat <= 12), "R8", lat, 5);
    cpu_req = 1; cpu_rw = 0; cpu_addr = 24'h020101; cpu_wdata = 8'h02;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 100);
    cpu_req = 0; bref[32'h020101] = 8'h02;
    chk(lat >= 10 && lat < 100, "R8", lat, 10);
    repeat (60) @(negedge clk);
    chk(dmem[32'h020100] == 8'h01 && dmem[32'h020101] == 8'h02, "R8", dmem[32'h020101], 8'h02);
    dsp_lat = 3;

    // R7 read inside window after drain
    access(0, 24'h020101, 8'h00);
    repeat (10) @(negedge clk);
    chk(d_cnt == ds0 && rd == 8'h02, "R7", d_cnt - ds0, 0);

    // R10 refresh rate while idle
    rf0 = m_ref;
    repeat (10 * P) @(negedge clk);
    chk((m_ref - rf0) >= 9 && (m_ref - rf0) <= 11, "R10", m_ref - rf0, 10);

    chk(t_err == 0, "R4", t_err, 0);
    chk(d_err == 0, "R9", d_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule